// File: doc/BRIEF.md
# Priority-Ripple Interlock for Chained FIFO Slices

This block coordinates a row of FIFO slices that share one input word boundary and one output word boundary, so that the row behaves as a single wider or deeper FIFO without any external AND of status flags. Each slice carries a small interlock. On the input side, it decides when the slice's input register may be re-initialized after its word has moved into the stack. On the output side, it decides when the slice may announce that its output register holds a valid word.

A per-slice role bit is captured while reset is held. A slice whose serial-input-enable line is LOW during reset becomes the head of the row and acts on its own requests straight away. Every other slice is a follower. A follower takes its input enable from the full flag of the slice ahead of it and its output enable from that slice's output-valid flag. Because of this, re-initialization and output-valid both ripple from the head to the tail in a fixed order. The row as a whole may accept a new word when the tail's full flag is HIGH, and it holds a valid output word when the tail's valid flag is HIGH. Data storage and the stack are outside this block: the arrival of a word (`wr`), the availability of a word at the stack bottom (`stk_rdy`) and the removal of an output word (`take`) all come in as per-slice inputs.

Top module: `slice_interlock_row`

## Requirements
- R1: While `rst_n` is LOW, every slice captures its role: it is the head when its input enable is LOW, otherwise a follower. The role holds until the next reset. After reset, `full_n` is all ones, and `ore` and `init_cmd` are all zeros. A follower that has a pending request acts only once its enable line goes LOW.
- R2: A HIGH on `wr[i]` at a clock edge drives `full_n[i]` LOW after that edge. `full_n` HIGH means the input register is not full.
- R3: When `tts_n` is sampled LOW at an edge and was sampled HIGH at the edge before, a head slice pulses `init_cmd` for one cycle after that edge and drives its `full_n` HIGH.
- R4: Holding `tts_n` LOW for many cycles produces only one `init_cmd` pulse per slice. A new pulse needs `tts_n` to go HIGH and then LOW again.
- R5: A follower with a pending re-initialization waits while its input enable (the full flag of the slice ahead) is HIGH. It pulses `init_cmd` after the first edge at which that enable is sampled LOW.
- R6: When a slice's re-initialization and `wr` fall on the same edge, `init_cmd` still pulses and the pending request clears, but the new word wins: `full_n` stays LOW.
- R7: A `pull` pulse sets a transfer request that stays pending until `stk_rdy[i]` is HIGH while the output register is empty (or is being emptied by `take[i]` in the same cycle). At that point the word is loaded and the request clears.
- R8: A head slice raises `ore` right after the edge at which its word is loaded.
- R9: A follower's `ore` rises only after an edge at which its output enable (the `ore` of the slice ahead) was HIGH. If all slices load on the same edge, slice k rises k cycles after the head.
- R10: A HIGH on `take[i]` with no new load drops `ore[i]` after that edge. When `take[i]` and a new load fall on the same edge, `ore[i]` stays HIGH.
- R11: `row_ready` equals the tail slice's `full_n`, and `row_valid` equals the tail slice's `ore`.
- R12: A follower that holds a word keeps `ore` LOW for as long as its output enable is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active LOW; the role is captured while it is LOW |
| head_ien_n | input | 1 | Input enable of slice 0; LOW makes slice 0 the head |
| head_oen | input | 1 | Output enable of slice 0; only matters when slice 0 is a follower |
| tts_n | input | 1 | Transfer-to-stack request, shared, active LOW, acted on at its falling edge |
| pull | input | 1 | Transfer-out request, shared, one pulse per word |
| wr | input | N_SLICES | Per-slice: input register was filled this cycle |
| take | input | N_SLICES | Per-slice: output word removed this cycle |
| stk_rdy | input | N_SLICES | Per-slice: a word is waiting at the stack bottom |
| init_cmd | output | N_SLICES | Per-slice one-cycle input-register initialize command |
| full_n | output | N_SLICES | Per-slice full flag, LOW when the input register is full |
| ore | output | N_SLICES | Per-slice output-valid flag after role gating |
| row_ready | output | 1 | Tail slice full flag; the row may take a new word |
| row_valid | output | 1 | Tail slice valid flag; the row output is valid |

## Verification
Two pairs of events can collide in one cycle. The first pair is re-initialization and the arrival of a new word in the same slice: the bench drops `tts_n` in the same cycle as `wr[0]` and expects the initialize pulse together with a `full_n` that stays LOW. The second pair is removal of the output word and loading of the next one: the bench raises `take` on every slice together with a `pull` while the stack is ready, and expects `ore` to stay HIGH on every slice instead of dropping for a cycle. Ripple order is judged by sampling `ore` cycle by cycle after a common load and confirming that slice k rises exactly k cycles after the head.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    // Input-side state of one slice
    typedef struct packed {
        logic full;      // input register holds a word
        logic pend;      // re-initialization requested, not yet granted
        logic init;      // registered initialize command
        logic tts_prev;  // tts_n as sampled at the previous edge
    } entry_st_t;

    // Output-side state of one slice
    typedef struct packed {
        logic req;       // transfer-out requested, word not yet loaded
        logic loaded;    // output register holds a word
        logic ore;       // gated output-valid flag
    } exit_st_t;

    localparam entry_st_t ENTRY_RST = '{full: 1'b0, pend: 1'b0, init: 1'b0, tts_prev: 1'b1};
    localparam exit_st_t  EXIT_RST  = '{req: 1'b0, loaded: 1'b0, ore: 1'b0};

endpackage

// File: rtl/ilk_entry_ctl.sv
module ilk_entry_ctl
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic ien_n_i,
    input  logic tts_n_i,
    input  logic wr_i,
    output logic init_cmd_o,
    output logic full_n_o
);

    entry_st_t st_q, st_d;
    logic      tts_fall, pending, fire;

    always_comb begin
        tts_fall    = st_q.tts_prev & ~tts_n_i;
        pending     = st_q.pend | tts_fall;
        fire        = pending & (master_i | ~ien_n_i);
        st_d.tts_prev = tts_n_i;
        st_d.pend     = pending & ~fire;
        st_d.init     = fire;
        st_d.full     = (st_q.full & ~fire) | wr_i;  // a new word wins over re-init
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ENTRY_RST;
        else        st_q <= st_d;
    end

    assign init_cmd_o = st_q.init;
    assign full_n_o   = ~st_q.full;

    // R2: a written word shows as full after the edge
    a_r2_wr_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> !full_n_o);

    // R3 / R5: an initialize pulse needs the head role or a LOW enable
    a_r5_init_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_cmd_o) |-> $past(master_i || !ien_n_i));

    // R4: never two initialize pulses back to back
    a_r4_single_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd_o |=> !init_cmd_o);

endmodule

// File: rtl/ilk_exit_ctl.sv
module ilk_exit_ctl
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic oen_i,
    input  logic pull_i,
    input  logic take_i,
    input  logic stk_rdy_i,
    output logic ore_o
);

    exit_st_t st_q, st_d;
    logic     want, load_now;

    always_comb begin
        want        = st_q.req | pull_i;
        load_now    = want & stk_rdy_i & (~st_q.loaded | take_i);
        st_d.req    = want & ~load_now;
        st_d.loaded = (st_q.loaded & ~take_i) | load_now;
        st_d.ore    = st_d.loaded & (master_i | oen_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EXIT_RST;
        else        st_q <= st_d;
    end

    assign ore_o = st_q.ore;

    // R9: a follower raises its flag only after its enable was seen HIGH
    a_r9_slave_order: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ore_o) |-> (master_i || $past(oen_i)));

    // R12: a follower with its enable LOW keeps the flag LOW
    a_r12_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_i && !oen_i) |=> !ore_o);

    // R10: removal with no stack word clears the flag
    a_r10_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !stk_rdy_i) |=> !ore_o);

endmodule

// File: rtl/ilk_slice.sv
module ilk_slice
    import ilk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ien_n_i,
    input  logic oen_i,
    input  logic tts_n_i,
    input  logic pull_i,
    input  logic wr_i,
    input  logic take_i,
    input  logic stk_rdy_i,
    output logic init_cmd_o,
    output logic full_n_o,
    output logic ore_o
);

    logic master_d, master_q;

    // Role is sampled only while reset is held
    always_comb begin
        master_d = rst_n ? master_q : ~ien_n_i;
    end

    always_ff @(posedge clk) begin
        master_q <= master_d;
    end

    ilk_entry_ctl u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_i   (master_q),
        .ien_n_i    (ien_n_i),
        .tts_n_i    (tts_n_i),
        .wr_i       (wr_i),
        .init_cmd_o (init_cmd_o),
        .full_n_o   (full_n_o)
    );

    ilk_exit_ctl u_exit (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_i  (master_q),
        .oen_i     (oen_i),
        .pull_i    (pull_i),
        .take_i    (take_i),
        .stk_rdy_i (stk_rdy_i),
        .ore_o     (ore_o)
    );

    // R1: the role bit does not move outside reset
    a_r1_role_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(master_q));

endmodule

// File: rtl/slice_interlock_row.sv
module slice_interlock_row #(
    parameter int N_SLICES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                head_ien_n,
    input  logic                head_oen,
    input  logic                tts_n,
    input  logic                pull,
    input  logic [N_SLICES-1:0] wr,
    input  logic [N_SLICES-1:0] take,
    input  logic [N_SLICES-1:0] stk_rdy,
    output logic [N_SLICES-1:0] init_cmd,
    output logic [N_SLICES-1:0] full_n,
    output logic [N_SLICES-1:0] ore,
    output logic                row_ready,
    output logic                row_valid
);

    localparam int LAST = N_SLICES - 1;

    logic [N_SLICES-1:0] ien_chain;
    logic [N_SLICES-1:0] oen_chain;

    for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
        if (i == 0) begin : g_head
            assign ien_chain[i] = head_ien_n;
            assign oen_chain[i] = head_oen;
        end else begin : g_follow
            assign ien_chain[i] = full_n[i-1];
            assign oen_chain[i] = ore[i-1];
        end

        ilk_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .ien_n_i    (ien_chain[i]),
            .oen_i      (oen_chain[i]),
            .tts_n_i    (tts_n),
            .pull_i     (pull),
            .wr_i       (wr[i]),
            .take_i     (take[i]),
            .stk_rdy_i  (stk_rdy[i]),
            .init_cmd_o (init_cmd[i]),
            .full_n_o   (full_n[i]),
            .ore_o      (ore[i])
        );
    end

    assign row_ready = full_n[LAST];
    assign row_valid = ore[LAST];

    // R11: the tail gates the row output
    a_r11_row_valid_tail: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |-> ore[LAST] && (N_SLICES == 1 || ore[0] || $past(ore[0])));

endmodule

// File: tb/slice_interlock_row_tb_top.sv
module slice_interlock_row_tb_top;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         head_ien_n, head_oen, tts_n, pull;
    logic [N-1:0] wr, take, stk_rdy;
    logic [N-1:0] init_cmd, full_n, ore;
    logic         row_ready, row_valid;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    slice_interlock_row #(.N_SLICES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .head_ien_n(head_ien_n), .head_oen(head_oen),
        .tts_n(tts_n), .pull(pull), .wr(wr), .take(take), .stk_rdy(stk_rdy),
        .init_cmd(init_cmd), .full_n(full_n), .ore(ore),
        .row_ready(row_ready), .row_valid(row_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset(input logic ien_n);
        rst_n = 1'b0; head_ien_n = ien_n; head_oen = 1'b0;
        tts_n = 1'b1; pull = 1'b0; wr = '0; take = '0; stk_rdy = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        head_ien_n = 1'b0;
        if (ien_n) head_ien_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 full_n after reset", full_n, 3'b111);
        chk("R1 ore after reset", ore, 3'b000);
        chk("R1 init_cmd after reset", init_cmd, 3'b000);
        chk("R11 row_ready after reset", row_ready, 1'b1);
    endtask

    task automatic t_fill_init();
        do_reset(1'b0);
        wr = 3'b111; tick(); wr = '0;
        chk("R2 full after wr", full_n, 3'b000);
        chk("R11 row_ready low when tail full", row_ready, 1'b0);
        tts_n = 1'b0; tick();
        chk("R3 init pulse all", init_cmd, 3'b111);
        chk("R3 full_n after init", full_n, 3'b111);
        tick();
        chk("R4 no second pulse while held", init_cmd, 3'b000);
        tick();
        chk("R4 still single pulse", init_cmd, 3'b000);
        tts_n = 1'b1; tick();
    endtask

    task automatic t_slave_wait();
        do_reset(1'b0);
        wr = 3'b110; tick(); wr = '0;
        chk("R2 partial fill", full_n, 3'b001);
        tts_n = 1'b0; tick(); tts_n = 1'b1;
        chk("R5 slice1 waits, others fire", init_cmd, 3'b101);
        chk("R5 full_n while waiting", full_n, 3'b101);
        tick();
        chk("R5 still waiting", full_n, 3'b101);
        wr = 3'b001; tick(); wr = '0;
        chk("R5 enable low only now", init_cmd, 3'b000);
        chk("R5 head full", full_n, 3'b100);
        tick();
        chk("R5 follower fires after enable low", init_cmd, 3'b010);
        chk("R5 follower empty", full_n, 3'b110);
    endtask

    task automatic t_collide_in();
        do_reset(1'b0);
        wr = 3'b001; tick();
        tts_n = 1'b0; wr = 3'b001; tick(); wr = '0; tts_n = 1'b1;
        chk("R6 init still pulses", init_cmd[0], 1'b1);
        chk("R6 new word keeps full", full_n[0], 1'b0);
        tick();
        chk("R6 pending cleared", init_cmd[0], 1'b0);
        chk("R6 full holds", full_n[0], 1'b0);
    endtask

    task automatic t_ripple();
        do_reset(1'b0);
        stk_rdy = 3'b111; pull = 1'b1; tick(); pull = 1'b0; stk_rdy = '0;
        chk("R8 head rises at load", ore, 3'b001);
        chk("R11 row_valid low", row_valid, 1'b0);
        tick();
        chk("R9 slice1 one cycle later", ore, 3'b011);
        tick();
        chk("R9 slice2 two cycles later", ore, 3'b111);
        chk("R11 row_valid high", row_valid, 1'b1);
        take = 3'b111; tick(); take = '0;
        chk("R10 take drops ore", ore, 3'b000);
        stk_rdy = 3'b111; pull = 1'b1; tick(); pull = 1'b0;
        tick(); tick();
        chk("R10 refilled", ore, 3'b111);
        pull = 1'b1; take = 3'b111; tick(); pull = 1'b0; take = '0; stk_rdy = '0;
        chk("R10 take with load keeps ore", ore, 3'b111);
    endtask

    task automatic t_no_data();
        do_reset(1'b0);
        pull = 1'b1; tick(); pull = 1'b0;
        chk("R7 no stack word no load", ore, 3'b000);
        tick();
        chk("R7 request pending", ore, 3'b000);
        stk_rdy = 3'b111; tick(); stk_rdy = '0;
        chk("R7 pending request loads", ore, 3'b001);
        tick(); tick();
        chk("R7 ripple completes", ore, 3'b111);
    endtask

    task automatic t_slave_gate();
        do_reset(1'b0);
        stk_rdy = 3'b110; pull = 1'b1; tick(); pull = 1'b0;
        chk("R12 followers gated", ore, 3'b000);
        tick();
        chk("R12 still gated", ore, 3'b000);
        stk_rdy = 3'b111; tick(); stk_rdy = '0;
        chk("R12 head now valid", ore, 3'b001);
        tick();
        chk("R12 slice1 released", ore, 3'b011);
        tick();
        chk("R12 slice2 released", ore, 3'b111);
    endtask

    task automatic t_head_follower();
        do_reset(1'b1);
        wr = 3'b001; tick(); wr = '0;
        tts_n = 1'b0; tick(); tts_n = 1'b1;
        chk("R1 non-head waits", init_cmd[0], 1'b0);
        chk("R1 non-head still full", full_n[0], 1'b0);
        head_ien_n = 1'b0; tick();
        chk("R1 fires when enable low", init_cmd[0], 1'b1);
        chk("R1 empty after late fire", full_n[0], 1'b1);
        stk_rdy = 3'b001; pull = 1'b1; tick(); pull = 1'b0; stk_rdy = '0;
        chk("R1 non-head ore gated", ore[0], 1'b0);
        tick();
        chk("R12 gated while oen low", ore[0], 1'b0);
        head_oen = 1'b1; tick();
        chk("R9 rises after oen", ore[0], 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_fill_init();
        t_slave_wait();
        t_collide_in();
        t_ripple();
        t_no_data();
        t_slave_gate();
        t_head_follower();
        finish_run();
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

endmodule